// File: doc/BRIEF.md
# Synchronous Graphics Memory Power-Up Sequencer

This block drives the command pins of a two-bank synchronous graphics memory from the moment reset is released until the memory can accept normal traffic. Clock enable and all byte-mask lines stay high, and the command lines carry no-operation while a stable-clock interval runs. The wait stands for about 200 microseconds, given as a cycle count. After it, the block issues an all-bank precharge, a parameterized number of auto-refresh commands (at least two) and a mode register load. An optional special-mode load can follow the mode load. Each command is followed by its own parameterized idle gap.

The mode register load may come before or after the refresh burst, chosen by a parameter. The mode word comes from an input, and the reserved top address bit is always forced to zero when it is loaded. The optional special-mode load carries a mask-load enable on address bit 5 and a color-load enable on address bit 6. The block never sets both bits. When both are requested, mask loading wins.

When the last gap has expired, a done flag rises and stays high. The pins then hold no-operation until the next reset. Periodic refresh and read/write traffic belong to other logic.

Top module: `sgram_init_seq`

## Requirements
- R1: During reset and in every cycle afterwards, `cke` is 1 and every bit of `dqm` is 1; while reset is low the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no-operation) and `init_done` is 0.
- R2: Counting the first cycle after reset release as cycle 0, cycles 0 to STABLE_CYC-1 show no-operation, and the first command appears in cycle STABLE_CYC.
- R3: The first command is a precharge, pins 4'b0010, with address bit PALL_BIT (default 8) set to 1 and every other address bit 0.
- R4: Exactly REF_COUNT auto-refresh commands are issued, pins 4'b0001, with an all-zero address.
- R5: With MRS_FIRST=0 the mode load follows the last refresh. With MRS_FIRST=1 the mode load (and the special load, if enabled) comes directly after the precharge gap, and the refreshes follow.
- R6: The mode load drives pins 4'b0000 with `dsf`=0 and an address equal to `mode_word`, except that the top address bit is 0.
- R7: With SPECIAL_EN=1 a special load (pins 4'b0000, `dsf`=1) directly follows the mode load gap. Its address is all zero except bit 5, which equals `mask_req`, and bit 6, which equals `color_req` AND NOT `mask_req`.
- R8: Each command lasts exactly one cycle. It is followed by T_PRE no-operation cycles after a precharge, T_REF after each refresh, and T_MRS after either kind of mode load.
- R9: `init_done` rises in the cycle after the last gap ends and stays 1. While it is 1 the pins show no-operation with `dsf`=0 and address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Active-low synchronous reset; restarts the sequence |
| mode_word | input | ADDR_W | Mode word placed on the address for the mode load |
| color_req | input | 1 | Request color-load enable in the special load |
| mask_req | input | 1 | Request mask-load enable in the special load |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable, held high |
| dqm | output | DQM_W | Byte data masks, held high |
| dsf | output | 1 | Function select; high only on the special load |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Initialization complete, sticky until reset |

## Verification
The hardest case to reach from the ports is the special load with both enables requested. It lasts one cycle near the end of a long sequence, and its address depends on the two request inputs in that cycle only. The bench runs two instances with opposite ordering and special-load settings through repeated full sequences. Each run applies a different mode word and one of the four request combinations. Every cycle of every run is compared with a schedule that the bench builds by adding up the gaps.

// File: rtl/sgram_init_pkg.sv
package sgram_init_pkg;

  typedef enum logic [1:0] {K_PRE, K_REF, K_MRS, K_SMRS} step_kind_e;
  typedef enum logic [1:0] {S_WAIT, S_CMD, S_GAP, S_DONE} seq_state_e;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP = 4'b0111;
  localparam logic [3:0] PINS_PRE = 4'b0010;
  localparam logic [3:0] PINS_REF = 4'b0001;
  localparam logic [3:0] PINS_LMR = 4'b0000;

  function automatic int unsigned max4(int unsigned a, int unsigned b,
                                       int unsigned c, int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // precharge + refreshes + mode load + optional special load
  function automatic int unsigned step_total(int unsigned nref, bit special);
    return 2 + nref + (special ? 1 : 0);
  endfunction

  function automatic step_kind_e step_kind(int unsigned k, bit mrs_first,
                                           int unsigned nref, bit special);
    int unsigned j;
    if (k == 0) return K_PRE;
    j = k - 1;
    if (mrs_first) begin
      if (j == 0) return K_MRS;
      if (special && j == 1) return K_SMRS;
      return K_REF;
    end
    if (j < nref) return K_REF;
    if (j == nref) return K_MRS;
    return K_SMRS;
  endfunction

  function automatic int unsigned step_gap(step_kind_e kind, int unsigned tpre,
                                           int unsigned tref, int unsigned tmrs);
    case (kind)
      K_PRE:   return tpre;
      K_REF:   return tref;
      default: return tmrs;
    endcase
  endfunction

  function automatic logic [3:0] kind_pins(step_kind_e kind);
    case (kind)
      K_PRE:   return PINS_PRE;
      K_REF:   return PINS_REF;
      default: return PINS_LMR;
    endcase
  endfunction

  // returns {color_enable, mask_enable}; mask has priority
  function automatic logic [1:0] special_bits(logic color, logic mask);
    return {color & ~mask, mask};
  endfunction

endpackage

// File: rtl/init_wait_counter.sv
module init_wait_counter #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] limit,
  output logic          expire
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (clear) cnt <= '0;
    else            cnt <= cnt + CW'(1);
  end

  assign expire = (cnt == limit);

  // the count never runs past the window the sequencer selected
  assert_cnt_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);

endmodule

// File: rtl/init_step_fsm.sv
module init_step_fsm
  import sgram_init_pkg::*;
#(
  parameter int unsigned STABLE_CYC = 10000,
  parameter int unsigned T_PRE      = 3,
  parameter int unsigned T_REF      = 8,
  parameter int unsigned T_MRS      = 2,
  parameter int unsigned REF_COUNT  = 2,
  parameter bit          MRS_FIRST  = 1'b0,
  parameter bit          SPECIAL_EN = 1'b1,
  parameter int unsigned CW         = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          expire,
  output logic          clear,
  output logic [CW-1:0] limit,
  output step_kind_e    kind,
  output logic          cmd_valid,
  output logic          done
);

  localparam int unsigned NSTEP = step_total(REF_COUNT, SPECIAL_EN);
  localparam int unsigned IW    = $clog2(NSTEP);

  seq_state_e    state, nxt;
  logic [IW-1:0] idx;
  logic          last;
  int unsigned   cur_gap;

  assign kind      = step_kind(int'(idx), MRS_FIRST, REF_COUNT, SPECIAL_EN);
  assign cur_gap   = step_gap(kind, T_PRE, T_REF, T_MRS);
  assign last      = (idx == IW'(NSTEP - 1));
  assign cmd_valid = (state == S_CMD);
  assign done      = (state == S_DONE);

  always_comb begin
    nxt   = state;
    clear = 1'b0;
    limit = '0;
    case (state)
      S_WAIT: begin
        limit = CW'(STABLE_CYC - 1);
        if (expire) begin
          nxt   = S_CMD;
          clear = 1'b1;
        end
      end
      S_CMD: begin
        limit = CW'(cur_gap - 1);
        nxt   = S_GAP;
        clear = 1'b1;
      end
      S_GAP: begin
        limit = CW'(cur_gap - 1);
        if (expire) begin
          clear = 1'b1;
          nxt   = last ? S_DONE : S_CMD;
        end
      end
      default: clear = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_WAIT;
      idx   <= '0;
    end else begin
      state <= nxt;
      if (state == S_GAP && expire && !last) idx <= idx + IW'(1);
    end
  end

  initial begin
    assert (REF_COUNT >= 2) else $error("REF_COUNT below 2");
    assert (STABLE_CYC >= 1 && T_PRE >= 1 && T_REF >= 1 && T_MRS >= 1)
      else $error("wait counts must be at least 1");
  end

  assert_idx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IW'(NSTEP - 1));

  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_GAP && expire && last) |=> done);

  assert_gap_follows_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> (state == S_GAP));

endmodule

// File: rtl/init_cmd_encode.sv
module init_cmd_encode
  import sgram_init_pkg::*;
#(
  parameter int unsigned ADDR_W    = 11,
  parameter int unsigned PALL_BIT  = 8,
  parameter int unsigned MASK_BIT  = 5,
  parameter int unsigned COLOR_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  step_kind_e        kind,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic              color_req,
  input  logic              mask_req,
  output logic [3:0]        pins,
  output logic              dsf,
  output logic [ADDR_W-1:0] addr
);

  logic [1:0] sp_bits;
  assign sp_bits = special_bits(color_req, mask_req);

  always_comb begin
    pins = PINS_NOP;
    dsf  = 1'b0;
    addr = '0;
    if (cmd_valid) begin
      pins = kind_pins(kind);
      case (kind)
        K_PRE: addr[PALL_BIT] = 1'b1;
        K_MRS: begin
          addr             = mode_word;
          addr[ADDR_W-1]   = 1'b0;
        end
        K_SMRS: begin
          dsf              = 1'b1;
          addr[MASK_BIT]   = sp_bits[0];
          addr[COLOR_BIT]  = sp_bits[1];
        end
        default: addr = '0;
      endcase
    end
  end

  assert_mrs_reserved_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pins == PINS_LMR && !dsf) |-> (addr[ADDR_W-1] == 1'b0));

  assert_special_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dsf |-> !(addr[MASK_BIT] && addr[COLOR_BIT]));

  assert_special_mask_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dsf && mask_req) |-> (addr[MASK_BIT] && !addr[COLOR_BIT]));

endmodule

// File: rtl/sgram_init_seq.sv
module sgram_init_seq
  import sgram_init_pkg::*;
#(
  parameter int unsigned ADDR_W     = 11,
  parameter int unsigned DQM_W      = 4,
  parameter int unsigned PALL_BIT   = 8,
  parameter int unsigned STABLE_CYC = 10000,
  parameter int unsigned T_PRE      = 3,
  parameter int unsigned T_REF      = 8,
  parameter int unsigned T_MRS      = 2,
  parameter int unsigned REF_COUNT  = 2,
  parameter bit          MRS_FIRST  = 1'b0,
  parameter bit          SPECIAL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] mode_word,
  input  logic              color_req,
  input  logic              mask_req,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm,
  output logic              dsf,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int unsigned LIM_MAX = max4(STABLE_CYC, T_PRE, T_REF, T_MRS);
  localparam int unsigned CW      = $clog2(LIM_MAX + 1);
  localparam int unsigned RCW     = $clog2(REF_COUNT + 1) + 1;

  logic          ctr_clear;
  logic          ctr_expire;
  logic [CW-1:0] ctr_limit;
  step_kind_e    step_k;
  logic          step_fire;
  logic [3:0]    pins;

  init_wait_counter #(.CW(CW)) u_ctr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (ctr_clear),
    .limit  (ctr_limit),
    .expire (ctr_expire)
  );

  init_step_fsm #(
    .STABLE_CYC (STABLE_CYC),
    .T_PRE      (T_PRE),
    .T_REF      (T_REF),
    .T_MRS      (T_MRS),
    .REF_COUNT  (REF_COUNT),
    .MRS_FIRST  (MRS_FIRST),
    .SPECIAL_EN (SPECIAL_EN),
    .CW         (CW)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire    (ctr_expire),
    .clear     (ctr_clear),
    .limit     (ctr_limit),
    .kind      (step_k),
    .cmd_valid (step_fire),
    .done      (init_done)
  );

  init_cmd_encode #(
    .ADDR_W   (ADDR_W),
    .PALL_BIT (PALL_BIT),
    .MASK_BIT (5),
    .COLOR_BIT(6)
  ) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (step_fire),
    .kind      (step_k),
    .mode_word (mode_word),
    .color_req (color_req),
    .mask_req  (mask_req),
    .pins      (pins),
    .dsf       (dsf),
    .addr      (addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign cke = 1'b1;
  assign dqm = '1;

  // observation state for the assertions below
  logic           seen_cmd;
  logic [RCW-1:0] ref_seen;
  logic [31:0]    nop_run;
  logic           cmd_on_pins;

  assign cmd_on_pins = (pins != PINS_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_cmd <= 1'b0;
      ref_seen <= '0;
      nop_run  <= '0;
    end else begin
      if (cmd_on_pins) seen_cmd <= 1'b1;
      if (pins == PINS_REF) ref_seen <= ref_seen + RCW'(1);
      if (!seen_cmd && !cmd_on_pins) nop_run <= nop_run + 32'd1;
    end
  end

  assert_first_wait_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on_pins && !seen_cmd) |-> (nop_run == 32'(STABLE_CYC)));

  assert_first_is_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_on_pins && !seen_cmd) |-> (pins == PINS_PRE && addr[PALL_BIT]));

  assert_ref_total_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done) |-> (ref_seen == RCW'(REF_COUNT)));

  assert_one_cycle_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_on_pins |=> !cmd_on_pins);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!cmd_on_pins && !dsf && addr == '0));

endmodule

// File: tb/sgram_init_seq_tb.sv
`timescale 1ns/1ps
module sgram_init_seq_tb_top;

  localparam int S   = 20;
  localparam int TP  = 2;
  localparam int TR  = 3;
  localparam int TM  = 2;
  localparam int NR  = 3;
  localparam int RUN = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] mw;
  logic        creq, mreq;

  logic       a_cs, a_ras, a_cas, a_we, a_cke, a_dsf, a_done;
  logic [3:0] a_dqm;
  logic [10:0] a_addr;
  logic       b_cs, b_ras, b_cas, b_we, b_cke, b_dsf, b_done;
  logic [3:0] b_dqm;
  logic [10:0] b_addr;

  int  total = 0;
  int  bad   = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  sgram_init_seq #(
    .STABLE_CYC(S), .T_PRE(TP), .T_REF(TR), .T_MRS(TM), .REF_COUNT(NR),
    .MRS_FIRST(1'b0), .SPECIAL_EN(1'b1)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .mode_word(mw), .color_req(creq), .mask_req(mreq),
    .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we), .cke(a_cke),
    .dqm(a_dqm), .dsf(a_dsf), .addr(a_addr), .init_done(a_done)
  );

  sgram_init_seq #(
    .STABLE_CYC(S), .T_PRE(TP), .T_REF(TR), .T_MRS(TM), .REF_COUNT(NR),
    .MRS_FIRST(1'b1), .SPECIAL_EN(1'b0)
  ) dut_b_i (
    .clk(clk), .rst_n(rst_n), .mode_word(mw), .color_req(creq), .mask_req(mreq),
    .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we), .cke(b_cke),
    .dqm(b_dqm), .dsf(b_dsf), .addr(b_addr), .init_done(b_done)
  );

  // expected {done, dsf, pins[3:0], addr[10:0]} for a given cycle after release
  function automatic logic [16:0] expect_out(bit mf, bit sp, int cyc,
                                             logic [10:0] w, bit c, bit m);
    int t;
    int n;
    int kd;
    logic [10:0] a;
    t = S;
    n = 2 + NR + (sp ? 1 : 0);
    for (int k = 0; k < n; k++) begin
      if (cyc < t) return {1'b0, 1'b0, 4'b0111, 11'h000};
      if (k == 0)      kd = 0;
      else if (mf)     kd = (k == 1) ? 2 : ((sp && k == 2) ? 3 : 1);
      else             kd = (k <= NR) ? 1 : ((k == NR + 1) ? 2 : 3);
      if (cyc == t) begin
        case (kd)
          0: return {1'b0, 1'b0, 4'b0010, 11'h100};
          1: return {1'b0, 1'b0, 4'b0001, 11'h000};
          2: return {1'b0, 1'b0, 4'b0000, w & 11'h3FF};
          default: begin
            a = 11'h000;
            if (m)      a = 11'h020;
            else if (c) a = 11'h040;
            return {1'b0, 1'b1, 4'b0000, a};
          end
        endcase
      end
      t = t + 1 + ((kd == 0) ? TP : ((kd == 1) ? TR : TM));
    end
    return {(cyc >= t), 1'b0, 4'b0111, 11'h000};
  endfunction

  function automatic string tag_of(logic [16:0] e, int cyc);
    if (e[16])                    return "R9";
    if (e[14:11] == 4'b0010)      return "R3";
    if (e[14:11] == 4'b0001)      return "R4";
    if (e[14:11] == 4'b0000)      return e[15] ? "R7" : "R5/R6";
    if (cyc < S)                  return "R2";
    return "R8";
  endfunction

  task automatic check_one(string who, bit mf, bit sp, int cyc,
                           logic [16:0] act, logic ck, logic [3:0] dm);
    logic [16:0] e;
    e = expect_out(mf, sp, cyc, mw, creq, mreq);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s %s cyc=%0d actual=%h expected=%h", tag_of(e, cyc), who, cyc, act, e);
    end
    total++;
    if (ck !== 1'b1 || dm !== 4'hF) begin
      bad++;
      $display("FAIL R1 %s cyc=%0d actual cke=%b dqm=%h expected cke=1 dqm=f", who, cyc, ck, dm);
    end
  endtask

  task automatic check_reset();
    total++;
    if ({a_cs, a_ras, a_cas, a_we} !== 4'b0111 || {b_cs, b_ras, b_cas, b_we} !== 4'b0111 ||
        a_done !== 1'b0 || b_done !== 1'b0 || a_cke !== 1'b1 || b_cke !== 1'b1 ||
        a_dqm !== 4'hF || b_dqm !== 4'hF) begin
      bad++;
      $display("FAIL R1 reset state actual a=%b%b%b%b/%b b=%b%b%b%b/%b expected 0111/0",
               a_cs, a_ras, a_cas, a_we, a_done, b_cs, b_ras, b_cas, b_we, b_done);
    end
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mw    = '0;
    creq  = 1'b0;
    mreq  = 1'b0;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      rst_n = 1'b0;
      mw    = (i == 15) ? 11'h7FF : (11'h400 ^ 11'(i * 147));
      creq  = i[0];
      mreq  = i[1];
      repeat (3) @(negedge clk);
      #1 check_reset();
      @(negedge clk);
      rst_n = 1'b1;
      for (int cyc = 0; cyc < RUN; cyc++) begin
        #1;
        check_one("dut_i", 1'b0, 1'b1, cyc, {a_done, a_dsf, a_cs, a_ras, a_cas, a_we, a_addr},
                  a_cke, a_dqm);
        check_one("dut_b_i", 1'b1, 1'b0, cyc, {b_done, b_dsf, b_cs, b_ras, b_cas, b_we, b_addr},
                  b_cke, b_dqm);
        @(negedge clk);
      end
    end
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule